// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Variable-Latency Execute

This block is a small in-order integer pipeline that runs three-register arithmetic programs held in a local instruction store. Each instruction passes through four stages: fetch/decode, operand read, execute and writeback. Fetch/decode, operand read and writeback take one cycle each. Execute takes one cycle for addition and subtraction, three for multiplication and five for division.

A long operation holds every younger instruction in place while it executes. Its result is passed straight from the execute stage into the operand read of a waiting dependent instruction.

To use the block, load a program through the program write port and seed the register file through the register write port. Then pulse `start_i` with the program length on `len_i`. `done_o` rises in the cycle the final instruction retires, and `cycles_o` then keeps the total run time. Register contents can be read at any time through a combinational read port.

Top module: `pipe4_core`

## Requirements
- R1: After reset, `done_o` is 0, `cycles_o` is 0, `retired_o` is 0 and every register reads 0.
- R2: Instruction word layout: opcode in bits [13:12], destination in bits [11:8], first source in bits [7:4], second source in bits [3:0]. The opcode values are 0 for add, 1 for subtract, 2 for multiply and 3 for divide.
- R3: Add and subtract write Rd = Rs1 + Rs2 and Rd = Rs1 - Rs2, both modulo 2^16.
- R4: Multiply writes the low 16 bits of the unsigned product.
- R5: Divide writes the unsigned quotient Rs1 / Rs2. When Rs2 is 0, the result is 0xFFFF.
- R6: The first instruction is fetched in cycle 1, the cycle after the start edge. A single-instruction program therefore completes in 3 + L cycles, where L is 1, 3 or 5 for add/sub, multiply or divide.
- R7: While a multi-cycle operation is executing, younger instructions keep their stage and writeback receives a bubble. A divide followed by two independent adds completes in 10 cycles.
- R8: A dependent instruction waits in operand read until its producer's last execute cycle, then takes the result directly. The program mul, div, add-of-both, sub completes in 13 cycles with correct values.
- R9: A register written back in a cycle is seen with its new value by an operand read in that same cycle.
- R10: `retired_o` rises by at most one per cycle. `done_o` rises in the cycle it reaches the program length. While done, `cycles_o` stays frozen at the run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Write one instruction word into the program store |
| prog_addr_i | input | 4 | Program store write address |
| prog_data_i | input | 14 | Instruction word to write |
| rf_we_i | input | 1 | Seed a register (ignored while running) |
| rf_addr_i | input | 4 | Register to seed |
| rf_data_i | input | 16 | Seed value |
| len_i | input | 5 | Number of instructions to run, sampled at start |
| start_i | input | 1 | Clear the pipeline and begin at address 0 |
| rd_addr_i | input | 4 | Register read select |
| rd_data_o | output | 16 | Register read value |
| done_o | output | 1 | High once the last instruction has retired |
| cycles_o | output | 16 | Cycles elapsed since start, frozen when done |
| retired_o | output | 5 | Instructions retired in this run |

## Verification
The block is run on several programs. Single-instruction programs of each class separate the three execute latencies. A divide followed by independent adds shows that stalls come from resource occupancy alone. The mul/div/add/sub chain shows that the dependent instruction is released exactly at its producer's last execute cycle. A back-to-back add pair at distance two exercises the writeback bypass, and wrap-around and divide-by-zero operands exercise the arithmetic edge cases. On every clock, the retire count, the cycle count and the done flag are compared against a schedule computed in the bench, so a stall or release that is off by a single cycle is caught.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;
endpackage

// File: rtl/pipe4_imem.sv
module pipe4_imem #(
  parameter int INS_W = 14,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [INS_W-1:0] wd_i,
  input  logic [AW-1:0]    ra_i,
  output logic [INS_W-1:0] rd_o
);
  logic [INS_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int NRD    = 3,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [RA_W-1:0]            wa_i,
  input  logic [DATA_W-1:0]          wd_i,
  input  logic [NRD-1:0][RA_W-1:0]   ra_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // write-first: a same-cycle write is visible on every read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = (we_i && wa_i == ra_i[p]) ? wd_i : regs_q[ra_i[p]];
  end
endmodule

// File: rtl/pipe4_exec.sv
module pipe4_exec
  import pipe4_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RA_W    = 4,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 5,
  localparam int LMAX   = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
  localparam int CW     = $clog2(LMAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_i,
  input  op_e               op_i,
  input  logic [RA_W-1:0]   rd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [RA_W-1:0]   rd_o,
  output logic [DATA_W-1:0] res_o
);
  logic              v_q;
  op_e               op_q;
  logic [RA_W-1:0]   rd_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [CW-1:0]     cnt_q, lat_m1;

  always_comb begin
    case (op_i)
      OP_MUL:  lat_m1 = CW'(LAT_MUL - 1);
      OP_DIV:  lat_m1 = CW'(LAT_DIV - 1);
      default: lat_m1 = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      op_q  <= OP_ADD;
      rd_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      v_q <= 1'b0;
    end else if (issue_i) begin
      v_q   <= 1'b1;
      op_q  <= op_i;
      rd_q  <= rd_i;
      a_q   <= a_i;
      b_q   <= b_i;
      cnt_q <= lat_m1;
    end else if (last_o) begin
      v_q <= 1'b0;
    end else if (v_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    case (op_q)
      OP_ADD:  res_o = a_q + b_q;
      OP_SUB:  res_o = a_q - b_q;
      OP_MUL:  res_o = a_q * b_q;
      default: res_o = (b_q == '0) ? '1 : a_q / b_q;
    endcase
  end

  assign busy_o = v_q;
  assign last_o = v_q && (cnt_q == '0);
  assign rd_o   = rd_q;
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NREG       = 16,
  parameter int IMEM_DEPTH = 16,
  parameter int LAT_MUL    = 3,
  parameter int LAT_DIV    = 5,
  parameter int CNT_W      = 16,
  localparam int RA_W      = $clog2(NREG),
  localparam int PA_W      = $clog2(IMEM_DEPTH),
  localparam int INS_W     = 2 + 3 * RA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PA_W-1:0]   prog_addr_i,
  input  logic [INS_W-1:0]  prog_data_i,
  input  logic              rf_we_i,
  input  logic [RA_W-1:0]   rf_addr_i,
  input  logic [DATA_W-1:0] rf_data_i,
  input  logic [PA_W:0]     len_i,
  input  logic              start_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic [PA_W:0]     retired_o
);
  localparam logic [PA_W:0]  ONE_P = 1;
  localparam logic [CNT_W-1:0] ONE_C = 1;

  logic              running, done_q;
  logic [PA_W:0]     len_q, pc_q, ret_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              if_v, of_v, wb_v;
  logic [INS_W-1:0]  if_ins, of_ins, imem_rd;
  logic [RA_W-1:0]   wb_rd;
  logic [DATA_W-1:0] wb_val;

  op_e               of_op;
  logic [RA_W-1:0]   of_rd, of_rs1, of_rs2;
  logic              ex_busy, ex_last;
  logic [RA_W-1:0]   ex_rd;
  logic [DATA_W-1:0] ex_res, opa, opb;
  logic [2:0][RA_W-1:0]   rf_ra;
  logic [2:0][DATA_W-1:0] rf_rd;
  logic              rf_we;
  logic              of_go, of_take, if_take, fetch_ok;

  assign of_op  = op_e'(of_ins[INS_W-1 -: 2]);
  assign of_rd  = of_ins[3*RA_W-1 -: RA_W];
  assign of_rs1 = of_ins[2*RA_W-1 -: RA_W];
  assign of_rs2 = of_ins[RA_W-1:0];

  // operand read advances only when execute is empty or in its final cycle
  assign of_go    = of_v && (!ex_busy || ex_last);
  assign of_take  = !of_v || of_go;
  assign if_take  = !if_v || of_take;
  assign fetch_ok = running && (pc_q < len_q);

  pipe4_imem #(.INS_W(INS_W), .DEPTH(IMEM_DEPTH)) i_imem (
    .clk_i (clk_i),
    .we_i  (prog_we_i),
    .wa_i  (prog_addr_i),
    .wd_i  (prog_data_i),
    .ra_i  (start_i ? '0 : pc_q[PA_W-1:0]),
    .rd_o  (imem_rd)
  );

  assign rf_we = wb_v || (rf_we_i && !running);
  assign rf_ra = {rd_addr_i, of_rs2, of_rs1};

  pipe4_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(3)) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .wa_i   (wb_v ? wb_rd : rf_addr_i),
    .wd_i   (wb_v ? wb_val : rf_data_i),
    .ra_i   (rf_ra),
    .rd_o   (rf_rd)
  );

  // forward from the producer's final execute cycle
  assign opa = (ex_last && ex_rd == of_rs1) ? ex_res : rf_rd[0];
  assign opb = (ex_last && ex_rd == of_rs2) ? ex_res : rf_rd[1];

  pipe4_exec #(
    .DATA_W(DATA_W), .RA_W(RA_W), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) i_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start_i),
    .issue_i (of_go),
    .op_i    (of_op),
    .rd_i    (of_rd),
    .a_i     (opa),
    .b_i     (opb),
    .busy_o  (ex_busy),
    .last_o  (ex_last),
    .rd_o    (ex_rd),
    .res_o   (ex_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running <= 1'b0;
      done_q  <= 1'b0;
      len_q   <= '0;
      pc_q    <= '0;
      ret_q   <= '0;
      cnt_q   <= '0;
      if_v    <= 1'b0;
      if_ins  <= '0;
      of_v    <= 1'b0;
      of_ins  <= '0;
      wb_v    <= 1'b0;
      wb_rd   <= '0;
      wb_val  <= '0;
    end else if (start_i) begin
      running <= (len_i != '0);
      done_q  <= (len_i == '0);
      len_q   <= len_i;
      pc_q    <= ONE_P;
      ret_q   <= '0;
      cnt_q   <= '0;
      if_v    <= (len_i != '0);
      if_ins  <= imem_rd;
      of_v    <= 1'b0;
      wb_v    <= 1'b0;
    end else begin
      if (if_take) begin
        if_v <= fetch_ok;
        if (fetch_ok) begin
          if_ins <= imem_rd;
          pc_q   <= pc_q + ONE_P;
        end
      end
      if (of_take) begin
        of_v   <= if_v;
        of_ins <= if_ins;
      end
      wb_v   <= ex_last;
      wb_rd  <= ex_rd;
      wb_val <= ex_res;
      if (running) cnt_q <= cnt_q + ONE_C;
      if (wb_v) begin
        ret_q <= ret_q + ONE_P;
        if (ret_q + ONE_P == len_q) begin
          done_q  <= 1'b1;
          running <= 1'b0;
        end
      end
    end
  end

  assign rd_data_o = rf_rd[2];
  assign done_o    = done_q;
  assign cycles_o  = cnt_q;
  assign retired_o = ret_q;
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk #(
  parameter int CNT_W = 16,
  parameter int PA_W  = 4,
  parameter int INS_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [CNT_W-1:0] cycles_o,
  input logic [PA_W:0]    retired_o,
  input logic [PA_W:0]    len_q,
  input logic             wb_v,
  input logic             ex_busy,
  input logic             ex_last,
  input logic             of_v,
  input logic [INS_W-1:0] of_ins
);
  assert_bubble_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_busy && !ex_last && !start_i) |=> !wb_v);

  assert_of_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_v && ex_busy && !ex_last && !start_i) |=> (of_v && $stable(of_ins)));

  assert_count_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(cycles_o)));

  assert_done_at_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (retired_o == len_q));

  assert_one_retire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (retired_o == $past(retired_o) || retired_o == $past(retired_o) + 1'b1));

  assert_retire_from_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wb_v) |=> $stable(retired_o));
endmodule

bind pipe4_core pipe4_core_chk #(.CNT_W(CNT_W), .PA_W(PA_W), .INS_W(INS_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .cycles_o  (cycles_o),
  .retired_o (retired_o),
  .len_q     (len_q),
  .wb_v      (wb_v),
  .ex_busy   (ex_busy),
  .ex_last   (ex_last),
  .of_v      (of_v),
  .of_ins    (of_ins)
);

// File: tb/test_pipe4_core.sv
module test_pipe4_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [3:0]  prog_addr_i = '0;
  logic [13:0] prog_data_i = '0;
  logic        rf_we_i = 1'b0;
  logic [3:0]  rf_addr_i = '0;
  logic [15:0] rf_data_i = '0;
  logic [4:0]  len_i = '0;
  logic        start_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        done_o;
  logic [15:0] cycles_o;
  logic [4:0]  retired_o;

  int errors = 0;
  int checks = 0;

  logic [13:0] prog [16];
  logic [15:0] init_r [16];
  int          plen;
  int          last_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe4_core i_pipe4_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
    .rf_we_i(rf_we_i), .rf_addr_i(rf_addr_i), .rf_data_i(rf_data_i),
    .len_i(len_i), .start_i(start_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .cycles_o(cycles_o), .retired_o(retired_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R2 layout: op[13:12] rd[11:8] rs1[7:4] rs2[3:0]
  function automatic logic [13:0] enc(input int op, input int rd, input int a, input int b);
    return {2'(op), 4'(rd), 4'(a), 4'(b)};
  endfunction

  function automatic logic [15:0] calc(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return 16'((32'(a) * 32'(b)) & 32'hFFFF);
      default: return (b == 0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  function automatic int lat(input int op);
    return (op == 2) ? 3 : (op == 3) ? 5 : 1;
  endfunction

  task automatic run_prog(input string treq, input string dreq);
    logic [15:0] exp_r [16];
    int wbq[$];
    int of_prev, pos_prev, poe_prev, total;
    for (int r = 0; r < 16; r++) exp_r[r] = init_r[r];
    // data model: in-order semantics
    for (int i = 0; i < plen; i++) begin
      int op = int'(prog[i][13:12]);
      exp_r[prog[i][11:8]] = calc(op, exp_r[prog[i][7:4]], exp_r[prog[i][3:0]]);
    end
    // timing model: stage entry cycles
    of_prev = 1; pos_prev = 0; poe_prev = 0;
    for (int i = 0; i < plen; i++) begin
      int if_t, of_t, po_s;
      if_t = of_prev;
      of_t = (if_t + 1 > pos_prev) ? if_t + 1 : pos_prev;
      po_s = (of_t + 1 > poe_prev + 1) ? of_t + 1 : poe_prev + 1;
      of_prev  = of_t;
      pos_prev = po_s;
      poe_prev = po_s + lat(int'(prog[i][13:12])) - 1;
      wbq.push_back(poe_prev + 1);
    end
    total = wbq[$];
    // load program and registers
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      prog_we_i = 1'b1; prog_addr_i = 4'(i); prog_data_i = prog[i];
    end
    @(negedge clk); prog_we_i = 1'b0;
    for (int r = 0; r < 16; r++) begin
      rf_we_i = 1'b1; rf_addr_i = 4'(r); rf_data_i = init_r[r];
      @(negedge clk);
    end
    rf_we_i = 1'b0;
    len_i = 5'(plen); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(cycles_o == 0 && retired_o == 0 && !done_o, "R6", "state after start", int'(cycles_o), 0);
    for (int k = 1; k <= total + 2; k++) begin
      int exp_ret = 0;
      int exp_cyc = (k < total) ? k : total;
      @(posedge clk); @(negedge clk);
      foreach (wbq[j]) if (wbq[j] <= k) exp_ret++;
      check(int'(retired_o) == exp_ret, treq, "retired per cycle", int'(retired_o), exp_ret);
      check(int'(cycles_o) == exp_cyc, "R10", "cycle count", int'(cycles_o), exp_cyc);
      check(done_o == (k >= total), "R10", "done flag", int'(done_o), int'(k >= total));
    end
    for (int r = 0; r < 16; r++) begin
      rd_addr_i = 4'(r); #1;
      check(rd_data_o == exp_r[r], dreq, $sformatf("reg %0d", r), int'(rd_data_o), int'(exp_r[r]));
    end
    last_total = int'(cycles_o);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) init_r[r] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done_o && cycles_o == 0 && retired_o == 0, "R1", "idle after reset", int'(cycles_o), 0);
    rd_addr_i = 4'd5; #1;
    check(rd_data_o == 0, "R1", "register cleared", int'(rd_data_o), 0);

    // R8: dependent chain, 13 cycles
    init_r[0] = 16'd7; init_r[1] = 16'd6; init_r[2] = 16'd100; init_r[3] = 16'd7; init_r[4] = 16'd5;
    prog[0] = enc(2, 5, 0, 1); prog[1] = enc(3, 6, 2, 3);
    prog[2] = enc(0, 7, 5, 6); prog[3] = enc(1, 8, 7, 4);
    plen = 4;
    run_prog("R8", "R2");
    check(last_total == 13, "R8", "chain total cycles", last_total, 13);

    // R6 single-op latencies
    prog[0] = enc(0, 9, 0, 1); plen = 1;
    run_prog("R6", "R3");
    check(last_total == 4, "R6", "single add cycles", last_total, 4);
    prog[0] = enc(2, 9, 0, 1);
    run_prog("R6", "R4");
    check(last_total == 6, "R6", "single mul cycles", last_total, 6);
    prog[0] = enc(3, 9, 2, 3);
    run_prog("R6", "R5");
    check(last_total == 8, "R6", "single div cycles", last_total, 8);

    // R7: independent work behind a divide
    prog[0] = enc(3, 9, 2, 3); prog[1] = enc(0, 10, 0, 1); prog[2] = enc(0, 11, 3, 4);
    plen = 3;
    run_prog("R7", "R3");
    check(last_total == 10, "R7", "div then two adds", last_total, 10);

    // R9: writeback bypass at distance two
    prog[0] = enc(0, 1, 0, 0); prog[1] = enc(0, 2, 3, 3); prog[2] = enc(0, 4, 1, 1);
    plen = 3;
    run_prog("R9", "R9");
    check(last_total == 6, "R9", "bypass program cycles", last_total, 6);

    // R3 R4 R5 edge arithmetic
    init_r[0] = 16'd0; init_r[2] = 16'd3; init_r[3] = 16'd5; init_r[5] = 16'hFFFF;
    init_r[6] = 16'd2; init_r[7] = 16'h1234; init_r[8] = 16'h0100;
    prog[0] = enc(1, 1, 2, 3); prog[1] = enc(3, 4, 2, 0);
    prog[2] = enc(2, 9, 7, 8); prog[3] = enc(0, 10, 5, 6);
    plen = 4;
    run_prog("R10", "R5");
    rd_addr_i = 4'd1; #1;
    check(rd_data_o == 16'hFFFE, "R3", "sub wraps", int'(rd_data_o), 16'hFFFE);
    rd_addr_i = 4'd4; #1;
    check(rd_data_o == 16'hFFFF, "R5", "divide by zero", int'(rd_data_o), 16'hFFFF);
    rd_addr_i = 4'd9; #1;
    check(rd_data_o == 16'h3400, "R4", "mul low word", int'(rd_data_o), 16'h3400);
    rd_addr_i = 4'd10; #1;
    check(rd_data_o == 16'h0001, "R3", "add wraps", int'(rd_data_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule